// File: doc/BRIEF.md
# Vector Register Busy Scoreboard with Timed Release

This block keeps one busy flag per physical vector register of a compute unit. Before an instruction issues, the scheduler presents its source and destination operands. Each operand is a base physical index plus a register count, because one operand can occupy several consecutive registers. The block answers in the same cycle with exactly one verdict: ready, a read-after-write stall, or a write-after-any stall.

When an instruction issues, its destination registers are marked busy. No mark is made for an atomic that returns no value, or when the lane execution mask is all zero. For an arithmetic instruction, each marked register starts its own down-counter. The counter is loaded with the narrow bypass latency, or with the wide one when the largest operand is over four bytes. The flag clears when the counter runs out. A load, a value-returning atomic or a memory sync keeps its registers busy until a return pulse names them. They are then freed on the following clock edge.

Top module: `vreg_scoreboard`

## Requirements
- R1: The verdict is a read-after-write stall (`chk_raw`=1) whenever any register covered by any source operand is busy. An operand covers registers base through base+count-1, and a count of 0 marks it unused.
- R2: The verdict is a write-after-any stall (`chk_wax`=1) when no source register is busy but some destination register is. Exactly one of `chk_ready`, `chk_raw`, `chk_wax` is 1 in every cycle.
- R3: An operand with a count above 1 makes each covered register take part individually in checking, marking and freeing. This holds for registers from the base up to the end of the register file.
- R4: An issue with `iss_class`=2 (atomic) and `iss_atom_ret`=0 marks no register busy.
- R5: An issue whose `iss_exec` mask is all zero marks no register busy, whatever its class.
- R6: An issue with `iss_class`=0 (arithmetic) leaves each destination register busy for exactly N sampled cycles after the issue edge. N is `cfg_sp_len` when `iss_wide`=0 and `cfg_dp_len` when `iss_wide`=1, and a length of 0 is treated as 1.
- R7: An issue with `iss_class`=1 (load), 3 (memory sync) or 2 with `iss_atom_ret`=1 keeps its registers busy with no time limit. After a `ret_valid` pulse that names them, they read busy for one more cycle and are then free.
- R8: A new mark on a register that has a pending release cancels that release. The register then follows the rules of the new issue.
- R9: When a mark and a release (timer expiry or return) hit the same register on the same edge, the register stays busy under the new mark.
- R10: While `rst` is high, every busy flag and every pending release is cleared on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sp_len | input | CNT_W | Narrow-operand bypass latency in cycles |
| cfg_dp_len | input | CNT_W | Wide-operand bypass latency in cycles |
| chk_src_base | input | NSRC*IDX_W | Source operand base indices, operand k in slice k |
| chk_src_cnt | input | NSRC*CNT_FW | Source operand register counts, 0 = unused |
| chk_dst_base | input | NDST*IDX_W | Destination operand base indices for the check |
| chk_dst_cnt | input | NDST*CNT_FW | Destination operand register counts for the check |
| chk_ready | output | 1 | No hazard on the presented operands |
| chk_raw | output | 1 | Stall caused by a busy source register |
| chk_wax | output | 1 | Stall caused by a busy destination register only |
| iss_valid | input | 1 | Instruction issues this cycle |
| iss_class | input | 2 | 0 arithmetic, 1 load, 2 atomic, 3 memory sync |
| iss_atom_ret | input | 1 | Atomic returns a value |
| iss_wide | input | 1 | Largest operand exceeds four bytes |
| iss_exec | input | LANES | Lane execution mask |
| iss_dst_base | input | NDST*IDX_W | Issued destination base indices |
| iss_dst_cnt | input | NDST*CNT_FW | Issued destination register counts |
| ret_valid | input | 1 | Returned data written this cycle |
| ret_dst_base | input | NDST*IDX_W | Base indices of the registers being written |
| ret_dst_cnt | input | NDST*CNT_FW | Register counts of the registers being written |
| busy_o | output | NUM_REGS | Busy flag of every physical register |

## Verification
The hardest case to reach from the ports is a new issue that lands on the exact edge where a register's counter expires or its return is applied. Random traffic seldom lines the two up. The bench therefore counts edges from a first arithmetic issue with a known short latency and places a load on the same register at the expiry edge. It also drives a return and a re-issue for one register in the same cycle. A long random phase then adds short latencies, multi-register spans and zero masks. A behavioural model compares every busy flag and every verdict in every cycle.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_ATOMIC = 2'd2,
        CLS_MSYNC  = 2'd3
    } op_class_e;

    // Per-register command produced by the top for each slot
    typedef struct packed {
        logic mark;    // set busy this edge
        logic timed;   // mark starts a bypass countdown
        logic ret;     // returned data written: free next edge
    } slot_cmd_t;

    function automatic logic in_span(input int base, input int cnt, input int idx);
        return (cnt != 0) && (idx >= base) && (idx < base + cnt);
    endfunction

endpackage

// File: rtl/vsb_span_decode.sv
module vsb_span_decode #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = 5,
    parameter int NOPS     = 2,
    parameter int CNT_FW   = 2
) (
    input  logic [NOPS*IDX_W-1:0]  base_i,
    input  logic [NOPS*CNT_FW-1:0] cnt_i,
    output logic [NUM_REGS-1:0]    mask_o
);
    import vsb_pkg::*;

    always_comb begin
        mask_o = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            for (int o = 0; o < NOPS; o++) begin
                if (in_span(int'(base_i[o*IDX_W +: IDX_W]),
                            int'(cnt_i[o*CNT_FW +: CNT_FW]), r))
                    mask_o[r] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vsb_slot.sv
module vsb_slot #(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  vsb_pkg::slot_cmd_t cmd,
    input  logic [CNT_W-1:0]  delay,
    output logic              busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (cmd.mark) begin
            busy  <= 1'b1;
            cnt_q <= cmd.timed ? delay : '0;
        end else if (cmd.ret) begin
            cnt_q <= CNT_W'(1);
        end else if (cnt_q == CNT_W'(1)) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/vreg_scoreboard.sv
module vreg_scoreboard #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter int NSRC     = 3,
    parameter int NDST     = 2,
    parameter int CNT_FW   = 2,
    parameter int CNT_W    = 6,
    parameter int LANES    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CNT_W-1:0]       cfg_sp_len,
    input  logic [CNT_W-1:0]       cfg_dp_len,
    input  logic [NSRC*IDX_W-1:0]  chk_src_base,
    input  logic [NSRC*CNT_FW-1:0] chk_src_cnt,
    input  logic [NDST*IDX_W-1:0]  chk_dst_base,
    input  logic [NDST*CNT_FW-1:0] chk_dst_cnt,
    output logic                   chk_ready,
    output logic                   chk_raw,
    output logic                   chk_wax,
    input  logic                   iss_valid,
    input  logic [1:0]             iss_class,
    input  logic                   iss_atom_ret,
    input  logic                   iss_wide,
    input  logic [LANES-1:0]       iss_exec,
    input  logic [NDST*IDX_W-1:0]  iss_dst_base,
    input  logic [NDST*CNT_FW-1:0] iss_dst_cnt,
    input  logic                   ret_valid,
    input  logic [NDST*IDX_W-1:0]  ret_dst_base,
    input  logic [NDST*CNT_FW-1:0] ret_dst_cnt,
    output logic [NUM_REGS-1:0]    busy_o
);
    import vsb_pkg::*;

    logic [NUM_REGS-1:0] src_mask, dstc_mask, iss_mask, ret_mask;
    logic                mark_en, timed_en;
    logic [CNT_W-1:0]    sel_len, rel_delay;

    vsb_span_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NOPS(NSRC), .CNT_FW(CNT_FW))
        u_src_dec (.base_i(chk_src_base), .cnt_i(chk_src_cnt), .mask_o(src_mask));
    vsb_span_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NOPS(NDST), .CNT_FW(CNT_FW))
        u_dstc_dec (.base_i(chk_dst_base), .cnt_i(chk_dst_cnt), .mask_o(dstc_mask));
    vsb_span_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NOPS(NDST), .CNT_FW(CNT_FW))
        u_iss_dec (.base_i(iss_dst_base), .cnt_i(iss_dst_cnt), .mask_o(iss_mask));
    vsb_span_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NOPS(NDST), .CNT_FW(CNT_FW))
        u_ret_dec (.base_i(ret_dst_base), .cnt_i(ret_dst_cnt), .mask_o(ret_mask));

    // Hazard verdict: source hazard outranks destination hazard
    always_comb begin
        chk_raw   = |(src_mask & busy_o);
        chk_wax   = !chk_raw && |(dstc_mask & busy_o);
        chk_ready = !chk_raw && !chk_wax;
    end

    // Issue qualification and release delay selection
    always_comb begin
        mark_en   = iss_valid && (|iss_exec) &&
                    !((op_class_e'(iss_class) == CLS_ATOMIC) && !iss_atom_ret);
        timed_en  = (op_class_e'(iss_class) == CLS_ALU);
        sel_len   = iss_wide ? cfg_dp_len : cfg_sp_len;
        rel_delay = (sel_len == '0) ? CNT_W'(1) : sel_len;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
        slot_cmd_t cmd;
        always_comb begin
            cmd.mark  = mark_en && iss_mask[r];
            cmd.timed = timed_en;
            cmd.ret   = ret_valid && ret_mask[r];
        end
        vsb_slot #(.CNT_W(CNT_W)) u_slot (
            .clk(clk), .rst(rst), .cmd(cmd), .delay(rel_delay), .busy(busy_o[r])
        );
    end
endmodule

// File: rtl/vreg_scoreboard_chk.sv
module vreg_scoreboard_chk #(
    parameter int NUM_REGS = 32,
    parameter int LANES    = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                chk_ready,
    input logic                chk_raw,
    input logic                chk_wax,
    input logic                iss_valid,
    input logic [1:0]          iss_class,
    input logic                iss_atom_ret,
    input logic [LANES-1:0]    iss_exec,
    input logic [NUM_REGS-1:0] busy_o,
    input logic [NUM_REGS-1:0] src_mask,
    input logic [NUM_REGS-1:0] iss_mask
);
    assert_one_verdict_R2: assert property (@(posedge clk) disable iff (rst)
        $countones({chk_ready, chk_raw, chk_wax}) == 1);

    assert_raw_has_cause_R1: assert property (@(posedge clk) disable iff (rst)
        chk_raw |-> ((src_mask & busy_o) != '0));

    assert_no_set_without_issue_R6: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |=> ((busy_o & ~$past(busy_o)) == '0));

    assert_atomic_noret_no_mark_R4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_class == 2'd2 && !iss_atom_ret) |=> ((busy_o & ~$past(busy_o)) == '0));

    assert_zero_exec_no_mark_R5: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_exec == '0) |=> ((busy_o & ~$past(busy_o)) == '0));

    assert_mark_sets_span_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_exec != '0 && !(iss_class == 2'd2 && !iss_atom_ret))
        |=> ((busy_o & $past(iss_mask)) == $past(iss_mask)));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (busy_o == '0));
endmodule

bind vreg_scoreboard vreg_scoreboard_chk #(.NUM_REGS(NUM_REGS), .LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .chk_ready(chk_ready), .chk_raw(chk_raw), .chk_wax(chk_wax),
    .iss_valid(iss_valid), .iss_class(iss_class), .iss_atom_ret(iss_atom_ret),
    .iss_exec(iss_exec), .busy_o(busy_o), .src_mask(src_mask), .iss_mask(iss_mask)
);

// File: tb/vreg_scoreboard_bench.sv
module vreg_scoreboard_bench;
    localparam int NR = 32, IW = 5, NS = 3, ND = 2, CF = 2, CW = 6, LN = 16;

    logic clk = 0, rst = 1;
    logic [CW-1:0] cfg_sp_len = 3, cfg_dp_len = 6;
    logic [NS*IW-1:0] chk_src_base = '0;
    logic [NS*CF-1:0] chk_src_cnt = '0;
    logic [ND*IW-1:0] chk_dst_base = '0, iss_dst_base = '0, ret_dst_base = '0;
    logic [ND*CF-1:0] chk_dst_cnt = '0, iss_dst_cnt = '0, ret_dst_cnt = '0;
    logic chk_ready, chk_raw, chk_wax;
    logic iss_valid = 0, iss_atom_ret = 0, iss_wide = 0, ret_valid = 0;
    logic [1:0] iss_class = 0;
    logic [LN-1:0] iss_exec = '1;
    logic [NR-1:0] busy_o;

    int n_tests = 0, n_fail = 0;
    int mb[NR];
    int mc[NR];
    bit done = 0;

    always #5 clk = ~clk;

    vreg_scoreboard #(.NUM_REGS(NR), .IDX_W(IW), .NSRC(NS), .NDST(ND), .CNT_FW(CF),
                      .CNT_W(CW), .LANES(LN)) u_vreg_scoreboard (
        .clk(clk), .rst(rst), .cfg_sp_len(cfg_sp_len), .cfg_dp_len(cfg_dp_len),
        .chk_src_base(chk_src_base), .chk_src_cnt(chk_src_cnt),
        .chk_dst_base(chk_dst_base), .chk_dst_cnt(chk_dst_cnt),
        .chk_ready(chk_ready), .chk_raw(chk_raw), .chk_wax(chk_wax),
        .iss_valid(iss_valid), .iss_class(iss_class), .iss_atom_ret(iss_atom_ret),
        .iss_wide(iss_wide), .iss_exec(iss_exec), .iss_dst_base(iss_dst_base),
        .iss_dst_cnt(iss_dst_cnt), .ret_valid(ret_valid), .ret_dst_base(ret_dst_base),
        .ret_dst_cnt(ret_dst_cnt), .busy_o(busy_o));

    function automatic bit covers(logic [ND*IW-1:0] b, logic [ND*CF-1:0] c, int nops, int r);
        for (int o = 0; o < nops; o++) begin
            int bb = int'(b[o*IW +: IW]);
            int cc = int'(c[o*CF +: CF]);
            if (cc > 0 && r >= bb && r < bb + cc) return 1;
        end
        return 0;
    endfunction

    function automatic bit covers_src(int r);
        for (int o = 0; o < NS; o++) begin
            int bb = int'(chk_src_base[o*IW +: IW]);
            int cc = int'(chk_src_cnt[o*CF +: CF]);
            if (cc > 0 && r >= bb && r < bb + cc) return 1;
        end
        return 0;
    endfunction

    // Behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        for (int r = 0; r < NR; r++) begin
            bit mk, rt;
            int len;
            mk = iss_valid && (iss_exec != 0) && !(iss_class == 2 && !iss_atom_ret)
                 && covers(iss_dst_base, iss_dst_cnt, ND, r);
            rt = ret_valid && covers(ret_dst_base, ret_dst_cnt, ND, r);
            len = iss_wide ? int'(cfg_dp_len) : int'(cfg_sp_len);
            if (len == 0) len = 1;
            if (rst) begin mb[r] = 0; mc[r] = 0; end
            else if (mk) begin mb[r] = 1; mc[r] = (iss_class == 0) ? len : 0; end
            else if (rt) mc[r] = 1;
            else if (mc[r] == 1) begin mb[r] = 0; mc[r] = 0; end
            else if (mc[r] > 1) mc[r] = mc[r] - 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #2;
        for (int r = 0; r < NR; r++)
            if (busy_o[r] !== mb[r][0]) begin
                n_fail++;
                $display("FAIL R6/R7/R8/R9 busy[%0d]: actual %0d expected %0d", r, busy_o[r], mb[r]);
            end
        n_tests++;
    endtask

    task automatic verdict(string tag);
        bit raw, wax;
        #1;
        raw = 0; wax = 0;
        for (int r = 0; r < NR; r++) begin
            if (mb[r] != 0 && covers_src(r)) raw = 1;
            if (mb[r] != 0 && covers(chk_dst_base, chk_dst_cnt, ND, r)) wax = 1;
        end
        check({tag, " raw"}, int'(chk_raw), int'(raw));
        check({tag, " wax"}, int'(chk_wax), int'(!raw && wax));
        check({tag, " ready"}, int'(chk_ready), int'(!raw && !wax));
    endtask

    task automatic probe(string tag, int sb, int sc, int db, int dc);
        chk_src_base = '0; chk_src_cnt = '0; chk_dst_base = '0; chk_dst_cnt = '0;
        chk_src_base[0 +: IW] = IW'(sb); chk_src_cnt[0 +: CF] = CF'(sc);
        chk_dst_base[0 +: IW] = IW'(db); chk_dst_cnt[0 +: CF] = CF'(dc);
        verdict(tag);
    endtask

    task automatic issue(int cls, bit aret, bit wide, int exec, int base, int cnt);
        iss_valid = 1; iss_class = 2'(cls); iss_atom_ret = aret; iss_wide = wide;
        iss_exec = LN'(exec); iss_dst_base = '0; iss_dst_cnt = '0;
        iss_dst_base[0 +: IW] = IW'(base); iss_dst_cnt[0 +: CF] = CF'(cnt);
    endtask

    task automatic give_ret(int base, int cnt);
        ret_valid = 1; ret_dst_base = '0; ret_dst_cnt = '0;
        ret_dst_base[0 +: IW] = IW'(base); ret_dst_cnt[0 +: CF] = CF'(cnt);
    endtask

    task automatic idle();
        iss_valid = 0; ret_valid = 0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick();
        rst = 0;
        check("R10 reset busy", int'(busy_o != 0), 0);
        probe("R10 reset verdict", 4, 3, 9, 2);

        // R6 narrow latency on reg 5
        issue(0, 0, 0, 1, 5, 1); tick(); idle();
        n = 0;
        for (int i = 0; i < 8; i++) begin if (busy_o[5]) n++; tick(); end
        check("R6 narrow busy cycles", n, 3);

        // R6 wide latency on regs 8..9 (R3 span)
        issue(0, 0, 1, 16'h00F0, 8, 2); tick(); idle();
        check("R3 span reg 9 marked", int'(busy_o[9]), 1);
        probe("R1 src span 7..9 hits", 7, 3, 0, 0);
        check("R1 raw span", int'(chk_raw), 1);
        probe("R2 src+dst busy raw wins", 8, 1, 9, 1);
        probe("R2 dst only", 1, 1, 9, 1);
        check("R2 wax", int'(chk_wax), 1);
        n = 1;
        for (int i = 0; i < 10; i++) begin tick(); if (busy_o[8]) n++; end
        check("R6 wide busy cycles", n, 6);

        // R4 non-returning atomic, R5 zero exec load
        issue(2, 0, 0, 1, 12, 1); tick();
        check("R4 atomic no mark", int'(busy_o[12]), 0);
        issue(1, 0, 0, 0, 13, 2); tick(); idle();
        check("R5 zero exec no mark", int'(busy_o[14:13]), 0);

        // R7 load held until return
        issue(1, 0, 0, 1, 20, 2); tick(); idle();
        repeat (20) tick();
        check("R7 load held", int'(busy_o[21:20]), 3);
        give_ret(20, 2); tick(); idle();
        check("R7 busy one cycle after return", int'(busy_o[20]), 1);
        tick();
        check("R7 freed", int'(busy_o[21:20]), 0);

        // R8 re-mark cancels pending timer
        issue(0, 0, 0, 1, 3, 1); tick(); tick();
        issue(1, 0, 0, 1, 3, 1); tick(); idle();
        repeat (8) tick();
        check("R8 timer cancelled", int'(busy_o[3]), 1);

        // R9 mark on expiry edge: cfg_sp_len=2, re-issue exactly 2 edges later
        cfg_sp_len = 2;
        issue(0, 0, 0, 1, 4, 1); tick(); idle(); tick();
        issue(1, 0, 0, 1, 4, 1); tick(); idle();
        repeat (3) tick();
        check("R9 mark beats expiry", int'(busy_o[4]), 1);
        // R9 mark and return same cycle
        issue(1, 0, 0, 1, 4, 1); give_ret(4, 1); tick(); idle();
        repeat (3) tick();
        check("R9 mark beats return", int'(busy_o[4]), 1);

        // R10 reset mid-flight
        rst = 1; tick(); rst = 0;
        check("R10 reset clears", int'(busy_o != 0), 0);

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            tick();
            if ($urandom_range(0, 49) == 0) cfg_sp_len = CW'($urandom_range(0, 4));
            if ($urandom_range(0, 49) == 0) cfg_dp_len = CW'($urandom_range(0, 7));
            iss_valid = ($urandom_range(0, 2) == 0);
            iss_class = 2'($urandom_range(0, 3));
            iss_atom_ret = 1'($urandom_range(0, 1));
            iss_wide = 1'($urandom_range(0, 1));
            iss_exec = ($urandom_range(0, 3) == 0) ? '0 : LN'($urandom);
            iss_dst_base = (ND*IW)'($urandom); iss_dst_cnt = (ND*CF)'($urandom);
            ret_valid = ($urandom_range(0, 2) == 0);
            ret_dst_base = (ND*IW)'($urandom); ret_dst_cnt = (ND*CF)'($urandom);
            chk_src_base = (NS*IW)'($urandom); chk_src_cnt = (NS*CF)'($urandom);
            chk_dst_base = (ND*IW)'($urandom); chk_dst_cnt = (ND*CF)'($urandom);
            verdict("R1/R2/R3 random");
        end
        idle();
        tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule